// File: doc/BRIEF.md
# Request-Paced Single-Channel Transfer Engine

This block is one data-moving channel that copies an 8-bit or 16-bit item from a memory-side source address to a peripheral-side destination address each time a peripheral raises its request line. Software programs a source address, a destination address, a byte count and a control word through a small write port. The channel then masters a single-cycle bus: one read cycle, one write cycle, and then a one-clock acknowledge pulse back to the peripheral so it can drop its request.

In the one-item-per-request mode the channel performs exactly one read/write pair per request and takes one or two bytes off the count. In the run-to-completion mode a single request starts a sequence that continues until the count is exhausted. When the count reaches zero a done flag sets and, if the auto-disable bit is set, the request-enable bit clears so that software must reprogram and re-enable the channel. A request that arrives with nothing valid to move (count zero, or an odd count with 16-bit items) sets a configuration-error flag and moves nothing.

Top module: `xfer_chan`

## Requirements
- R1: With the one-per-request bit (control bit 0) set, each accepted request produces exactly one bus read from the source address followed in the next cycle by one bus write to the destination address, and the channel then idles until the next request.
- R2: Each completed transfer lowers the count by 1 when the item-size bit (control bit 3) is 0 and by 2 when it is 1; the source address advances by the same amount when control bit 4 is set, the destination address when control bit 5 is set, and otherwise each stays put.
- R3: A request that arrives while request-enable is set and the count is zero causes no bus cycle and sets the error flag.
- R4: While request-enable (control bit 1) is 0, a request causes no bus cycle, no count change and no flag change.
- R5: With the auto-disable bit (control bit 2) set, request-enable clears in the same clock edge that the count reaches zero; with it clear, request-enable stays set.
- R6: The done flag sets when a transfer brings the count to zero; writing a value with bit 0 set to the status selector clears both done and error.
- R7: With 16-bit items, a request arriving while the count is odd sets the error flag, performs no bus cycle and leaves the count unchanged.
- R8: A byte transfer writes the low byte of the read data with the upper byte zero; a 16-bit transfer writes all 16 read bits; bus_word follows control bit 3.
- R9: With control bit 0 clear, one accepted request keeps transferring items until the count reaches zero, with an acknowledge after each item.
- R10: The peripheral acknowledge is high for exactly one clock, in the cycle after each bus write, and never otherwise.
- R11: The configuration port writes the register picked by cfg_sel (0 source, 1 destination, 2 count, 3 control, 4 status); the new value is visible on the status outputs one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register selector for the write |
| cfg_wdata | input | ADDR_W | Configuration write data |
| periph_req | input | 1 | Peripheral transfer request (level) |
| periph_ack | output | 1 | One-clock acknowledge after each transfer |
| bus_req | output | 1 | Bus cycle active |
| bus_we | output | 1 | Bus cycle is a write |
| bus_word | output | 1 | Bus cycle is 16-bit (else 8-bit) |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid in the read cycle |
| stat_cnt | output | CNT_W | Current byte count |
| stat_done | output | 1 | Done flag |
| stat_err | output | 1 | Configuration-error flag |
| stat_erq | output | 1 | Request-enable bit |

## Verification
The bench drives requests against counts of zero, odd counts with 16-bit items and counts that run out mid-sequence, since a channel that checked the count too late would issue a bus cycle past zero or wrap the count to its maximum. It holds a request high with request-enable clear and then after auto-disable, where a faulty gate would start unwanted transfers. It checks address stepping with each increment bit on and off and both item sizes, which catches a wrong step size or a swapped address, and it runs a run-to-completion sequence, where a channel that stopped after one item or skipped the acknowledge would leave the count nonzero or the acknowledge count short.

// File: rtl/xfer_chan_pkg.sv
package xfer_chan_pkg;

    localparam int DATA_W = 16;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_STAT = 3'd4;

    localparam int CB_ONE  = 0;
    localparam int CB_ERQ  = 1;
    localparam int CB_ADIS = 2;
    localparam int CB_WORD = 3;
    localparam int CB_SINC = 4;
    localparam int CB_DINC = 5;

    typedef struct packed {
        logic one;
        logic erq;
        logic adis;
        logic word;
        logic sinc;
        logic dinc;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_ACK
    } seq_state_e;

endpackage

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs
    import xfer_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              step_i,
    input  logic              err_set_i,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              cnt_zero_o,
    output ctrl_t             ctrl_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        ctrl_t             ctrl;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;
    logic [CNT_W-1:0] step_amt;

    always_comb begin
        step_amt = r_q.ctrl.word ? CNT_W'(2) : CNT_W'(1);
        r_d = r_q;
        if (step_i) begin
            r_d.cnt = r_q.cnt - step_amt;
            if (r_q.ctrl.sinc) r_d.src = r_q.src + ADDR_W'(step_amt);
            if (r_q.ctrl.dinc) r_d.dst = r_q.dst + ADDR_W'(step_amt);
            if (r_q.cnt == step_amt) begin
                r_d.done = 1'b1;
                if (r_q.ctrl.adis) r_d.ctrl.erq = 1'b0;
            end
        end
        if (err_set_i) r_d.err = 1'b1;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_SRC:  r_d.src = cfg_wdata;
                SEL_DST:  r_d.dst = cfg_wdata;
                SEL_CNT:  r_d.cnt = cfg_wdata[CNT_W-1:0];
                SEL_CTRL: begin
                    r_d.ctrl.one  = cfg_wdata[CB_ONE];
                    r_d.ctrl.erq  = cfg_wdata[CB_ERQ];
                    r_d.ctrl.adis = cfg_wdata[CB_ADIS];
                    r_d.ctrl.word = cfg_wdata[CB_WORD];
                    r_d.ctrl.sinc = cfg_wdata[CB_SINC];
                    r_d.ctrl.dinc = cfg_wdata[CB_DINC];
                end
                SEL_STAT: begin
                    if (cfg_wdata[0]) begin
                        r_d.done = 1'b0;
                        r_d.err  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src_o      = r_q.src;
    assign dst_o      = r_q.dst;
    assign cnt_o      = r_q.cnt;
    assign cnt_zero_o = (r_q.cnt == '0);
    assign ctrl_o     = r_q.ctrl;
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;

    // R2: count steps by the item size on each transfer
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cfg_we) |=> (r_q.cnt == $past(r_q.cnt) - $past(step_amt)));

    // R5: auto-disable drops request-enable at the last item
    a_r5_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cfg_we && r_q.ctrl.adis && r_q.cnt == step_amt) |=> !r_q.ctrl.erq);

    // R6: done rises when the last item completes
    a_r6_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cfg_we && r_q.cnt == step_amt) |=> r_q.done);

    // R3: a transfer never happens with nothing left to move
    a_r3_no_step_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (r_q.cnt >= step_amt));

endmodule

// File: rtl/xfer_chan_seq.sv
module xfer_chan_seq
    import xfer_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              one_i,
    input  logic              erq_i,
    input  logic              word_i,
    input  logic              cnt_zero_i,
    input  logic              cnt_odd_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              ack_o,
    output logic              step_o,
    output logic              err_set_o
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        step_o    = 1'b0;
        err_set_o = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_i && erq_i) begin
                    if (cnt_zero_i || (word_i && cnt_odd_i)) err_set_o = 1'b1;
                    else                                      s_d.st    = ST_RD;
                end
            end
            ST_RD: begin
                s_d.data = word_i ? bus_rdata
                                  : {{(DATA_W-HALF_W){1'b0}}, bus_rdata[HALF_W-1:0]};
                s_d.st   = ST_WR;
            end
            ST_WR: begin
                step_o = 1'b1;
                s_d.st = ST_ACK;
            end
            ST_ACK: begin
                if (!one_i && erq_i && !cnt_zero_i) s_d.st = ST_RD;
                else                                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, data: '0};
        else        s_q <= s_d;
    end

    assign bus_req   = (s_q.st == ST_RD) || (s_q.st == ST_WR);
    assign bus_we    = (s_q.st == ST_WR);
    assign bus_addr  = (s_q.st == ST_WR) ? dst_i : src_i;
    assign bus_wdata = s_q.data;
    assign ack_o     = (s_q.st == ST_ACK);

    // R1: a write is always followed by the acknowledge
    a_r1_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> ack_o);

    // R1: a read is always followed by the write
    a_r1_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> (bus_req && bus_we));

    // R10: acknowledge lasts one clock
    a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R7: an error decision starts no bus cycle
    a_r7_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        err_set_o |=> !bus_req);

    // R4: a sequence starts only with requests enabled
    a_r4_start_needs_erq: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && !bus_req && !erq_i) |=> !bus_req);

endmodule

// File: rtl/xfer_chan.sv
module xfer_chan
    import xfer_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata,
    output logic [CNT_W-1:0]  stat_cnt,
    output logic              stat_done,
    output logic              stat_err,
    output logic              stat_erq
);

    logic [ADDR_W-1:0] src_w, dst_w;
    logic              cnt_zero_w, step_w, err_set_w;
    ctrl_t             ctrl_w;

    xfer_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .step_i     (step_w),
        .err_set_i  (err_set_w),
        .src_o      (src_w),
        .dst_o      (dst_w),
        .cnt_o      (stat_cnt),
        .cnt_zero_o (cnt_zero_w),
        .ctrl_o     (ctrl_w),
        .done_o     (stat_done),
        .err_o      (stat_err)
    );

    xfer_chan_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (periph_req),
        .one_i      (ctrl_w.one),
        .erq_i      (ctrl_w.erq),
        .word_i     (ctrl_w.word),
        .cnt_zero_i (cnt_zero_w),
        .cnt_odd_i  (stat_cnt[0]),
        .src_i      (src_w),
        .dst_i      (dst_w),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ack_o      (periph_ack),
        .step_o     (step_w),
        .err_set_o  (err_set_w)
    );

    assign bus_word = ctrl_w.word;
    assign stat_erq = ctrl_w.erq;

    // R3: a read never starts with a zero count
    a_r3_read_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (stat_cnt != '0));

    // R6: error flag only rises through a refused request
    a_r6_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_err) |-> $past(periph_req && stat_erq));

endmodule

// File: tb/xfer_chan_bench.sv
module xfer_chan_bench;
    import xfer_chan_pkg::*;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          periph_req = 1'b0;
    logic          periph_ack, bus_req, bus_we, bus_word;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;
    logic [CW-1:0] stat_cnt;
    logic          stat_done, stat_err, stat_erq;

    int tests = 0;
    int fails = 0;
    int n_rd = 0, n_wr = 0, n_ack = 0;
    logic [AW-1:0] last_raddr = '0, last_waddr = '0;
    logic [15:0]   last_wdata = '0;
    logic          last_wword = 1'b0;

    always #5 clk = ~clk;

    assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

    xfer_chan #(.ADDR_W(AW), .CNT_W(CW)) u_xfer_chan (.*);

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !bus_we) begin n_rd++; last_raddr = bus_addr; end
            if (bus_req && bus_we) begin
                n_wr++; last_waddr = bus_addr; last_wdata = bus_wdata; last_wword = bus_word;
            end
            if (periph_ack) n_ack++;
        end
    end

    function automatic logic [15:0] mem_val(input logic [AW-1:0] a, input logic word);
        logic [15:0] v;
        v = a[15:0] ^ 16'hA5C3;
        return word ? v : {8'h00, v[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input string tag);
        int n;
        @(negedge clk);
        periph_req = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!periph_ack && n < 20);
        periph_req = 1'b0;
        chk({tag, " ack seen"}, AW'(periph_ack), AW'(1));
        @(negedge clk);
        chk("R10 ack one clock", AW'(periph_ack), AW'(0));
    endtask

    task automatic hold_req(input int cycles);
        @(negedge clk);
        periph_req = 1'b1;
        repeat (cycles) @(negedge clk);
        periph_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [AW-1:0] ctrl_word(input logic one, input logic erq, input logic adis,
                                                input logic word, input logic sinc, input logic dinc);
        logic [AW-1:0] c;
        c = '0;
        c[CB_ONE] = one; c[CB_ERQ] = erq; c[CB_ADIS] = adis;
        c[CB_WORD] = word; c[CB_SINC] = sinc; c[CB_DINC] = dinc;
        return c;
    endfunction

    typedef struct packed {
        logic          word;
        logic          sinc;
        logic          dinc;
        logic [CW-1:0] cnt;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 16'd5, 32'h0000_0100, 32'h0000_8000},
        '{1'b1, 1'b1, 1'b1, 16'd8, 32'h0000_2002, 32'h0000_9000},
        '{1'b1, 1'b0, 1'b1, 16'd4, 32'h0000_30FE, 32'h0000_A010},
        '{1'b0, 1'b0, 1'b0, 16'd3, 32'h0000_0055, 32'h0000_B000}
    };

    initial begin
        int rd0, wr0, ack0;
        logic [CW-1:0] inc;
        repeat (3) @(negedge clk);
        // reset state
        chk("R11 reset count", AW'(stat_cnt), AW'(0));
        chk("R6 reset done", AW'(stat_done), AW'(0));
        chk("R6 reset err", AW'(stat_err), AW'(0));
        chk("R4 reset erq", AW'(stat_erq), AW'(0));
        chk("R10 reset ack", AW'(periph_ack), AW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle bus", AW'(bus_req), AW'(0));

        // R11 count readback
        wr(SEL_CNT, 32'd77);
        chk("R11 count readback", AW'(stat_cnt), AW'(77));

        for (int i = 0; i < NV; i++) begin
            inc = VEC[i].word ? CW'(2) : CW'(1);
            wr(SEL_STAT, 32'd1);
            wr(SEL_SRC, VEC[i].src);
            wr(SEL_DST, VEC[i].dst);
            wr(SEL_CNT, AW'(VEC[i].cnt));
            wr(SEL_CTRL, ctrl_word(1'b1, 1'b1, 1'b0, VEC[i].word, VEC[i].sinc, VEC[i].dinc));
            rd0 = n_rd; wr0 = n_wr;
            do_req("R1 first");
            chk("R1 one read", AW'(n_rd - rd0), AW'(1));
            chk("R1 one write", AW'(n_wr - wr0), AW'(1));
            chk("R1 read addr", last_raddr, VEC[i].src);
            chk("R1 write addr", last_waddr, VEC[i].dst);
            chk("R8 data", AW'(last_wdata), AW'(mem_val(VEC[i].src, VEC[i].word)));
            chk("R8 bus_word", AW'(last_wword), AW'(VEC[i].word));
            chk("R2 count after one", AW'(stat_cnt), AW'(VEC[i].cnt - inc));
            do_req("R1 second");
            chk("R2 src step", last_raddr, VEC[i].src + (VEC[i].sinc ? AW'(inc) : '0));
            chk("R2 dst step", last_waddr, VEC[i].dst + (VEC[i].dinc ? AW'(inc) : '0));
            chk("R8 data second", AW'(last_wdata),
                AW'(mem_val(VEC[i].src + (VEC[i].sinc ? AW'(inc) : '0), VEC[i].word)));
            chk("R2 count after two", AW'(stat_cnt), AW'(VEC[i].cnt - 2*inc));
            chk("R6 done", AW'(stat_done), AW'((VEC[i].cnt - 2*inc) == 0));
            chk("R5 erq kept", AW'(stat_erq), AW'(1));
        end

        // R4: request ignored while disabled
        wr(SEL_STAT, 32'd1);
        wr(SEL_CNT, 32'd4);
        wr(SEL_CTRL, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        rd0 = n_rd; wr0 = n_wr; ack0 = n_ack;
        hold_req(8);
        chk("R4 no bus", AW'(n_rd + n_wr - rd0 - wr0), AW'(0));
        chk("R4 no ack", AW'(n_ack - ack0), AW'(0));
        chk("R4 count kept", AW'(stat_cnt), AW'(4));
        chk("R4 no err", AW'(stat_err), AW'(0));

        // R5: auto-disable
        wr(SEL_SRC, 32'h600); wr(SEL_DST, 32'h700);
        wr(SEL_CNT, 32'd2);
        wr(SEL_CTRL, ctrl_word(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
        do_req("R5 first");
        chk("R5 erq mid", AW'(stat_erq), AW'(1));
        do_req("R5 last");
        chk("R5 erq cleared", AW'(stat_erq), AW'(0));
        chk("R6 done at zero", AW'(stat_done), AW'(1));
        chk("R2 count zero", AW'(stat_cnt), AW'(0));
        rd0 = n_rd;
        hold_req(5);
        chk("R5 disabled no bus", AW'(n_rd - rd0), AW'(0));
        chk("R5 disabled no err", AW'(stat_err), AW'(0));

        // R3: request at zero count with enable set
        wr(SEL_CTRL, ctrl_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        rd0 = n_rd; wr0 = n_wr;
        hold_req(5);
        chk("R3 no bus", AW'(n_rd + n_wr - rd0 - wr0), AW'(0));
        chk("R3 err set", AW'(stat_err), AW'(1));
        chk("R3 count kept", AW'(stat_cnt), AW'(0));
        // R6 write-one clear
        wr(SEL_STAT, 32'd0);
        chk("R6 zero write keeps err", AW'(stat_err), AW'(1));
        wr(SEL_STAT, 32'd1);
        chk("R6 clear done", AW'(stat_done), AW'(0));
        chk("R6 clear err", AW'(stat_err), AW'(0));

        // R7: odd count with 16-bit items
        wr(SEL_CNT, 32'd3);
        wr(SEL_CTRL, ctrl_word(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        rd0 = n_rd; wr0 = n_wr;
        hold_req(5);
        chk("R7 no bus", AW'(n_rd + n_wr - rd0 - wr0), AW'(0));
        chk("R7 err set", AW'(stat_err), AW'(1));
        chk("R7 count kept", AW'(stat_cnt), AW'(3));
        wr(SEL_STAT, 32'd1);

        // R9: run to completion on one request
        wr(SEL_SRC, 32'h40); wr(SEL_DST, 32'hC000);
        wr(SEL_CNT, 32'd3);
        wr(SEL_CTRL, ctrl_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
        wr0 = n_wr; ack0 = n_ack;
        do_req("R9 start");
        for (int k = 0; k < 40 && !stat_done; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 writes", AW'(n_wr - wr0), AW'(3));
        chk("R9 acks", AW'(n_ack - ack0), AW'(3));
        chk("R9 last addr", last_waddr, 32'hC002);
        chk("R9 last data", AW'(last_wdata), AW'(mem_val(32'h42, 1'b0)));
        chk("R9 count zero", AW'(stat_cnt), AW'(0));
        chk("R9 done", AW'(stat_done), AW'(1));
        chk("R9 no err", AW'(stat_err), AW'(0));

        chk("R10 ack per write", AW'(n_ack), AW'(n_wr));
        finish_run();
    end

endmodule